// File: doc/BRIEF.md
# Locked Command Mailbox

This block is a memory-mapped slave that several processing elements share in order to hand commands to a scheduler core. It holds one command word, a parameterised set of argument words, a busy flag and an ownership lock. A requester must first win the lock by reading the lock register. It then loads its arguments and writes the command. That command write starts the core and sets the block busy.

While busy, the core writes its results back into the argument words through a dedicated port. It then pulses done, and the block returns to idle. The requester polls status until it reads idle, collects the results, and writes the lock register to give up ownership. There is no queue in hardware: a requester that fails to get the lock simply polls again.

The core's interrupt requests are spread out to one line per processing element. They are gated so that lines pulse only while a command is executing.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the lock is free, status reads 0 (idle), the command and argument words read 0, and `core_start_o` and `irq_o` are low.
- R2: A read of the lock register (word 2) returns 1 and makes the caller's `bus_id_i` the owner when the lock is free. It returns 0 and leaves the owner unchanged when the lock is held.
- R3: Writes to the command word (word 0) or an argument word (words 4 onward, argument k at word 4+k) from a requester other than the owner are dropped, and they raise no start pulse.
- R4: When the block is idle, writes by the owner land in the addressed word, and any requester can read every word back at any time.
- R5: A command write by the owner (even with no arguments loaded) raises `core_start_o` for exactly one cycle, starting at the clock edge that takes the write. `core_cmd_o` shows the new code, and status (word 1, bit 0) reads 1 from that edge on.
- R6: While busy, command and argument writes from the bus are dropped and raise no new start pulse.
- R7: A core result write (`core_wr_i`, index `core_wr_idx_i`) lands in the selected argument word. A `core_done_i` pulse clears busy on the same edge.
- R8: A write to the lock register releases the lock only if it comes from the owner while status is idle. A release attempt while busy, or from a requester that is not the owner, is ignored.
- R9: `irq_o` has one bit per requester. A bit pulses for one cycle, one cycle after the matching `core_irq_i` bit rises, and only if the block is busy. A request that is held high gives a single pulse, and a request raised while idle gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_id_i | input | ID_W | Requester ID |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational for the current access |
| core_start_o | output | 1 | One-cycle start pulse to the core |
| core_cmd_o | output | DATA_W | Current command code |
| core_args_o | output | NUM_ARGS*DATA_W | All argument words, argument 0 in the low bits |
| core_wr_i | input | 1 | Core result write strobe |
| core_wr_idx_i | input | IDX_W | Argument index of the result write |
| core_wr_data_i | input | DATA_W | Result data |
| core_done_i | input | 1 | Command finished pulse |
| core_irq_i | input | NUM_REQ | Interrupt requests from the core |
| irq_o | output | NUM_REQ | One interrupt line per requester |

## Verification
The bench first checks that a second requester's lock read fails and leaves ownership alone; a design that let it through would accept the intruder's writes and mix arguments from two requesters. It then attempts writes and a release while the block is busy. A design that missed these cases would overwrite operands the core is reading, fire a second start, or free the lock before the results could be collected. It also holds an interrupt request high across cycles and raises another while idle, which exposes level pass-through and a missing busy gate. Finally, it checks that done clears busy on the same edge as the last result write, so that a requester never reads idle before its results are in place.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W      = 4;
  localparam int ADDR_CMD    = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_LOCK   = 2;
  localparam int ADDR_ARG0   = 4;
  localparam int MAX_ARGS    = (1 << ADDR_W) - ADDR_ARG0;
endpackage

// File: rtl/mbx_lock.sv
module mbx_lock #(
  parameter int ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acquire_i,
  input  logic            release_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            busy_i,
  output logic            held_o,
  output logic [ID_W-1:0] owner_o
);
  logic            held_q;
  logic [ID_W-1:0] owner_q;
  logic            grant, free_ok;

  assign grant   = acquire_i && !held_q;
  assign free_ok = release_i && held_q && (id_i == owner_q) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (grant) begin
      held_q  <= 1'b1;
      owner_q <= id_i;
    end else if (free_ok) begin
      held_q  <= 1'b0;
    end
  end

  assign held_o  = held_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs #(
  parameter int DATA_W   = 32,
  parameter int NUM_ARGS = 4,
  localparam int IDX_W   = $clog2(NUM_ARGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_we_i,
  input  logic [NUM_ARGS-1:0]        arg_we_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  input  logic                       core_we_i,
  input  logic [IDX_W-1:0]           core_idx_i,
  input  logic [DATA_W-1:0]          core_wdata_i,
  output logic [DATA_W-1:0]          cmd_o,
  output logic [NUM_ARGS*DATA_W-1:0] args_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_o <= '0;
    else if (cmd_we_i) cmd_o <= bus_wdata_i;
  end

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
    logic [DATA_W-1:0] arg_q;
    logic              core_hit;
    assign core_hit = core_we_i && (core_idx_i == IDX_W'(g));
    // core result writes win over the bus
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          arg_q <= '0;
      else if (core_hit)    arg_q <= core_wdata_i;
      else if (arg_we_i[g]) arg_q <= bus_wdata_i;
    end
    assign args_o[g*DATA_W +: DATA_W] = arg_q;
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int NUM_REQ = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] irq_o
);
  logic [NUM_REQ-1:0] last_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      irq_q  <= '0;
    end else begin
      last_q <= req_i;
      irq_q  <= busy_i ? (req_i & ~last_q) : '0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_REQ  = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_ARGS = 4,
  localparam int ID_W    = $clog2(NUM_REQ),
  localparam int IDX_W   = $clog2(NUM_ARGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_valid_i,
  input  logic                       bus_write_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [ID_W-1:0]            bus_id_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic                       core_start_o,
  output logic [DATA_W-1:0]          core_cmd_o,
  output logic [NUM_ARGS*DATA_W-1:0] core_args_o,
  input  logic                       core_wr_i,
  input  logic [IDX_W-1:0]           core_wr_idx_i,
  input  logic [DATA_W-1:0]          core_wr_data_i,
  input  logic                       core_done_i,
  input  logic [NUM_REQ-1:0]         core_irq_i,
  output logic [NUM_REQ-1:0]         irq_o
);
  initial begin
    if (NUM_ARGS < 2 || NUM_ARGS > MAX_ARGS) $error("NUM_ARGS out of range");
  end

  logic              busy_q, start_q;
  logic              lock_held;
  logic [ID_W-1:0]   lock_owner;
  logic              rd_en, wr_en, wr_ok;
  logic              lock_rd, lock_wr, cmd_we;
  logic [NUM_ARGS-1:0] arg_we;

  assign rd_en   = bus_valid_i && !bus_write_i;
  assign wr_en   = bus_valid_i &&  bus_write_i;
  assign wr_ok   = wr_en && lock_held && (bus_id_i == lock_owner) && !busy_q;
  assign lock_rd = rd_en && (bus_addr_i == ADDR_W'(ADDR_LOCK));
  assign lock_wr = wr_en && (bus_addr_i == ADDR_W'(ADDR_LOCK));
  assign cmd_we  = wr_ok && (bus_addr_i == ADDR_W'(ADDR_CMD));

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_dec
    assign arg_we[g] = wr_ok && (bus_addr_i == ADDR_W'(ADDR_ARG0 + g));
  end

  mbx_lock #(.ID_W(ID_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acquire_i (lock_rd),
    .release_i (lock_wr),
    .id_i      (bus_id_i),
    .busy_i    (busy_q),
    .held_o    (lock_held),
    .owner_o   (lock_owner)
  );

  mbx_regs #(.DATA_W(DATA_W), .NUM_ARGS(NUM_ARGS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we),
    .arg_we_i     (arg_we),
    .bus_wdata_i  (bus_wdata_i),
    .core_we_i    (core_wr_i),
    .core_idx_i   (core_wr_idx_i),
    .core_wdata_i (core_wr_data_i),
    .cmd_o        (core_cmd_o),
    .args_o       (core_args_o)
  );

  mbx_irq #(.NUM_REQ(NUM_REQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_q),
    .req_i  (core_irq_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= cmd_we;
      if (cmd_we)           busy_q <= 1'b1;
      else if (core_done_i) busy_q <= 1'b0;
    end
  end

  assign core_start_o = start_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(ADDR_CMD))    bus_rdata_o = core_cmd_o;
    if (bus_addr_i == ADDR_W'(ADDR_STATUS)) bus_rdata_o = DATA_W'(busy_q);
    if (bus_addr_i == ADDR_W'(ADDR_LOCK))   bus_rdata_o = DATA_W'(!lock_held);
    for (int i = 0; i < NUM_ARGS; i++) begin
      if (bus_addr_i == ADDR_W'(ADDR_ARG0 + i))
        bus_rdata_o = core_args_o[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int NUM_REQ  = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_ARGS = 4,
  localparam int ID_W    = $clog2(NUM_REQ)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       core_start_o,
  input logic                       busy_q,
  input logic                       lock_held,
  input logic [ID_W-1:0]            lock_owner,
  input logic                       core_done_i,
  input logic                       core_wr_i,
  input logic [NUM_ARGS*DATA_W-1:0] core_args_o,
  input logic [NUM_REQ-1:0]         irq_o
);
  assert_start_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |=> !core_start_o);
  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> busy_q);
  assert_owner_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_held && $past(lock_held)) |-> $stable(lock_owner));
  assert_busy_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> lock_held);
  assert_done_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && core_done_i) |=> !busy_q);
  assert_args_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !core_wr_i) |=> $stable(core_args_o));
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(busy_q));
endmodule

bind cmd_mailbox mbx_checker #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .NUM_ARGS(NUM_ARGS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .core_start_o (core_start_o),
  .busy_q       (busy_q),
  .lock_held    (lock_held),
  .lock_owner   (lock_owner),
  .core_done_i  (core_done_i),
  .core_wr_i    (core_wr_i),
  .core_args_o  (core_args_o),
  .irq_o        (irq_o)
);

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
  localparam int CLK_P    = 10;
  localparam int NUM_REQ  = 32;
  localparam int DATA_W   = 32;
  localparam int NUM_ARGS = 4;
  localparam int ID_W     = $clog2(NUM_REQ);
  localparam int IDX_W    = $clog2(NUM_ARGS);

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [3:0] bus_addr = '0;
  logic [ID_W-1:0] bus_id = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata;
  logic core_start;
  logic [DATA_W-1:0] core_cmd;
  logic [NUM_ARGS*DATA_W-1:0] core_args;
  logic core_wr = 0, core_done = 0;
  logic [IDX_W-1:0] core_idx = '0;
  logic [DATA_W-1:0] core_wdata = '0;
  logic [NUM_REQ-1:0] core_irq = '0, irq;

  always #(CLK_P/2) clk = ~clk;

  cmd_mailbox #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .NUM_ARGS(NUM_ARGS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_id_i(bus_id), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .core_start_o(core_start), .core_cmd_o(core_cmd), .core_args_o(core_args),
    .core_wr_i(core_wr), .core_wr_idx_i(core_idx), .core_wr_data_i(core_wdata),
    .core_done_i(core_done), .core_irq_i(core_irq), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;

  typedef struct { logic [DATA_W-1:0] exp; string req; } exp_t;
  exp_t sb_q[$];
  bit rd_pend = 0;

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compares read data against queued expectations
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rd_pend) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, bus_rdata, e.exp);
    end
  end

  task automatic bus_rd(logic [3:0] a, int id, logic [DATA_W-1:0] exp, string req);
    exp_t e;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_id = ID_W'(id);
    e.exp = exp; e.req = req;
    sb_q.push_back(e);
    rd_pend = 1;
    @(posedge clk); #1;
    bus_valid = 0; rd_pend = 0;
  endtask

  task automatic bus_wr(logic [3:0] a, int id, logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_id = ID_W'(id); bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  initial begin
    #(CLK_P*50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 start", 32'(core_start), 0);
    check("R1 irq", irq, 0);
    bus_rd(1, 3, 0, "R1 status idle");
    bus_rd(4, 3, 0, "R1 arg0 zero");
    bus_rd(2, 3, 1, "R2 acquire free");
    bus_rd(2, 5, 0, "R2 acquire held");
    bus_wr(4, 5, 32'hAAAA);
    bus_rd(4, 5, 0, "R3 foreign arg write dropped");
    bus_wr(0, 5, 32'h9);
    check("R3 no start", 32'(core_start), 0);
    bus_rd(0, 3, 0, "R3 foreign cmd dropped");
    bus_wr(4, 3, 32'h1234);
    bus_rd(4, 5, 32'h1234, "R4 owner write readable");
    bus_wr(0, 3, 32'h7);
    check("R5 start pulse", 32'(core_start), 1);
    check("R5 cmd out", core_cmd, 32'h7);
    @(posedge clk); #1;
    check("R5 single pulse", 32'(core_start), 0);
    bus_rd(1, 3, 1, "R5 status busy");
    bus_wr(5, 3, 32'h55);
    bus_rd(5, 3, 0, "R6 arg write while busy dropped");
    bus_wr(0, 3, 32'h8);
    check("R6 no restart", 32'(core_start), 0);
    bus_rd(0, 3, 32'h7, "R6 cmd kept");
    bus_wr(2, 3, 0);
    bus_rd(2, 5, 0, "R8 release while busy ignored");
    @(negedge clk); core_irq = (32'h1 << 3) | (32'h1 << 9);
    @(posedge clk); #1;
    check("R9 irq pulse", irq, (32'h1 << 3) | (32'h1 << 9));
    @(posedge clk); #1;
    check("R9 held request single pulse", irq, 0);
    @(negedge clk); core_irq = '0;
    core_wr = 1; core_idx = 2; core_wdata = 32'hBEEF; core_done = 1;
    @(posedge clk); #1;
    core_wr = 0; core_done = 0;
    bus_rd(1, 3, 0, "R7 done clears busy");
    bus_rd(6, 5, 32'hBEEF, "R7 result in arg2");
    @(negedge clk); core_irq = 32'h1 << 4;
    @(posedge clk); #1;
    check("R9 no irq while idle", irq, 0);
    @(negedge clk); core_irq = '0;
    bus_wr(2, 5, 0);
    bus_rd(2, 7, 0, "R8 foreign release ignored");
    bus_wr(2, 3, 0);
    bus_rd(2, 5, 1, "R8 owner release frees lock");
    bus_wr(4, 5, 32'h77);
    bus_rd(4, 3, 32'h77, "R4 new owner write");
    bus_wr(0, 5, 32'h21);
    check("R5 no-arg command starts", 32'(core_start), 1);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule